// File: doc/BRIEF.md
# Core Ready Handshake Generator

This block produces the readiness flag that a hardened core presents to the programmable fabric around it. It also produces the safe values that the core's fabric-facing outputs take while the core is not ready. The fabric sends three qualifying signals: configuration complete, I/O tri-state release and an active-low global reset. Each one is brought into the system clock domain. The flag rises only after all three have been high together for a fixed number of qualification cycles. A full reconfiguration withdraws configuration-complete or the I/O release, and this drops the flag; the same qualification then runs again. A partial reconfiguration is announced on a separate indicator, which is synchronous to the system clock, and the flag stays high while it is set.

While the flag is low, the local bus outputs are all forced to one. The active-high control outputs (protection switch, overhead clock enable and frame pulses) are all forced to zero. Once the flag is high, both groups pass the core's own values through unchanged.

Top module: `core_ready_gen`

## Requirements
- R1: While rst_n is low the block sets ready_o to 0, every bit of bus_o to 1 and every bit of ctl_o to 0.
- R2: After configuration-done, I/O release and rst_n are all high, ready_o rises on exactly the eighth rising clock edge. That is two synchroniser stages plus six qualification cycles (DELAY=6), and ready_o is still 0 after the seventh edge.
- R3: While ready_o is 0, bus_o is all ones whatever the value on bus_i.
- R4: While ready_o is 0, ctl_o is all zeros whatever the value on ctl_i.
- R5: While ready_o is 1, bus_o equals bus_i and ctl_o equals ctl_i.
- R6: With partial_cfg_i low, taking cfg_done_i or io_release_i low while ready_o is high makes ready_o fall on the third rising edge. After the signal returns high, ready_o rises again on the eighth rising edge.
- R7: While partial_cfg_i is 1, ready_o stays high even when cfg_done_i and io_release_i go low.
- R8: If a qualifying input drops during qualification while partial_cfg_i is 0, the count restarts. ready_o then rises on the eighth rising edge after the input returns high.
- R9: rst_n going low forces ready_o to 0 at once, without waiting for a clock edge. The release of reset is synchronised, so it follows the R2 timing.
- R10: If a qualifying input drops during qualification while partial_cfg_i is 1, the count is held rather than cleared. Each synchronised low cycle delays the rise of ready_o by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low global reset, also a qualifying signal |
| cfg_done_i | input | 1 | Fabric configuration complete (asynchronous) |
| io_release_i | input | 1 | I/O tri-state release (asynchronous) |
| partial_cfg_i | input | 1 | Partial reconfiguration in progress, synchronous to clk |
| bus_i | input | 32 | Core's local bus output values |
| ctl_i | input | 5 | Core's active-high control output values |
| ready_o | output | 1 | Core ready flag to the fabric |
| bus_o | output | 32 | Local bus outputs after the not-ready forcing |
| ctl_o | output | 5 | Control outputs after the not-ready forcing |

## Verification
The hardest cases to reach are a qualifying input that drops in the middle of the six-cycle count. Whether partial reconfiguration is flagged decides between a restart and a hold, and the two cases differ at the ports only by the cycle in which ready_o rises. The stimulus drives a one-cycle low pulse on cfg_done_i a known number of edges after qualification starts, once with partial_cfg_i low and once with it high. The scoreboard then expects ready_o to stay low at one sampling point and to be high at the next, which pins the exact cycle of the rise.

// File: rtl/crg_pkg.sv
package crg_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned delay);
    return (delay < 2) ? 1 : $clog2(delay);
  endfunction

  // Total edges from all qualifiers high to ready high.
  function automatic int unsigned rise_latency(input int unsigned delay);
    return SYNC_STAGES + delay;
  endfunction

endpackage

// File: rtl/crg_reset_sync.sv
module crg_reset_sync
  import crg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/crg_sync_bank.sv
module crg_sync_bank
  import crg_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[SYNC_STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = stage_q[SYNC_STAGES-1];
  end

endmodule

// File: rtl/crg_qualifier.sv
module crg_qualifier
  import crg_pkg::*;
#(
  parameter int unsigned DELAY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_s,
  input  logic rel_s,
  input  logic partial,
  output logic ready
);

  localparam int unsigned CW = cnt_width(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  // Named events.
  logic all_ok, count_done, reconfig_drop, restart, hold;
  assign all_ok        = done_s & rel_s;
  assign count_done    = !ready_q && all_ok && (cnt_q == LAST);
  assign reconfig_drop = ready_q && !all_ok && !partial;
  assign restart       = !ready_q && !all_ok && !partial;
  assign hold          = !ready_q && !all_ok && partial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (ready_q) begin
      if (reconfig_drop) begin
        ready_q <= 1'b0;
        cnt_q   <= '0;
      end
    end else if (count_done) begin
      ready_q <= 1'b1;
      cnt_q   <= '0;
    end else if (all_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (restart) begin
      cnt_q <= '0;
    end
  end

  assign ready = ready_q;

  assert_rise_after_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(cnt_q) == LAST));
  assert_drop_on_reconfig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !partial && !(done_s && rel_s)) |=> !ready_q);
  assert_hold_partial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && partial) |=> ready_q);
  assert_restart_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && !partial && !(done_s && rel_s)) |=> (cnt_q == '0));
  assert_hold_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && partial && !(done_s && rel_s)) |=> $stable(cnt_q));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/crg_out_gate.sv
module crg_out_gate #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned CTL_W = 5
) (
  input  logic             ready,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [CTL_W-1:0] ctl_o
);

  for (genvar b = 0; b < BUS_W; b++) begin : g_bus
    assign bus_o[b] = bus_i[b] | ~ready;
  end

  for (genvar c = 0; c < CTL_W; c++) begin : g_ctl
    assign ctl_o[c] = ctl_i[c] & ready;
  end

endmodule

// File: rtl/core_ready_gen.sv
module core_ready_gen
  import crg_pkg::*;
#(
  parameter int unsigned DELAY = 6,
  parameter int unsigned BUS_W = 32,
  parameter int unsigned CTL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done_i,
  input  logic             io_release_i,
  input  logic             partial_cfg_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic             ready_o,
  output logic [BUS_W-1:0] bus_o,
  output logic [CTL_W-1:0] ctl_o
);

  logic       rst_sync_n;
  logic [1:0] qual_s;
  logic       ready;

  crg_reset_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  crg_sync_bank #(.N(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({io_release_i, cfg_done_i}),
    .sync_o (qual_s)
  );

  // The synchronised reset is the third qualifier; it gates the whole qualifier.
  crg_qualifier #(.DELAY(DELAY)) u_qual (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .done_s (qual_s[0]),
    .rel_s  (qual_s[1]),
    .partial(partial_cfg_i),
    .ready  (ready)
  );

  crg_out_gate #(.BUS_W(BUS_W), .CTL_W(CTL_W)) u_gate (
    .ready(ready),
    .bus_i(bus_i),
    .ctl_i(ctl_i),
    .bus_o(bus_o),
    .ctl_o(ctl_o)
  );

  assign ready_o = ready;

  assert_ready_low_in_reset_R1: assert property (@(posedge clk) disable iff (rst_n)
    !ready_o);
  assert_not_ready_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> !ready_o);

endmodule

// File: tb/sim_core_ready_gen.sv
`timescale 1ns/1ps
module sim_core_ready_gen;

  localparam int BUS_W = 32;
  localparam int CTL_W = 5;
  localparam int LAT   = 2 + 6;   // sync stages + qualification cycles

  logic             clk = 1'b0;
  logic             rst_n, done, rel, partial;
  logic [BUS_W-1:0] bus_i;
  logic [CTL_W-1:0] ctl_i;
  logic             ready_o;
  logic [BUS_W-1:0] bus_o;
  logic [CTL_W-1:0] ctl_o;

  core_ready_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done_i(done), .io_release_i(rel),
    .partial_cfg_i(partial), .bus_i(bus_i), .ctl_i(ctl_i),
    .ready_o(ready_o), .bus_o(bus_o), .ctl_o(ctl_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit drv_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    bit         rdy;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic expect_at(input int off, input bit rdy, input string tag);
    exp_t e;
    e.at = cyc + off; e.rdy = rdy; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_now(input bit rdy, input string tag);
    logic [BUS_W-1:0] eb;
    logic [CTL_W-1:0] ec;
    eb = rdy ? bus_i : {BUS_W{1'b1}};
    ec = rdy ? ctl_i : {CTL_W{1'b0}};
    checks++;
    if (ready_o !== rdy || bus_o !== eb || ctl_o !== ec) begin
      errors++;
      $display("FAIL %s cyc=%0d: ready=%b bus=%h ctl=%b expected ready=%b bus=%h ctl=%b",
               tag, cyc, ready_o, bus_o, ctl_o, rdy, eb, ec);
    end
  endtask

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check_now(e.rdy, e.tag);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 0; done = 0; rel = 0; partial = 0;
    bus_i = 32'h1234_5678; ctl_i = 5'b10101;
    step(3);
    check_now(1'b0, "R1 reset state");
    // R2 / R3 / R4: release everything together.
    done = 1; rel = 1;
    step(2);
    check_now(1'b0, "R3 R4 forced while configuring");
    rst_n = 1;
    expect_at(LAT - 1, 1'b0, "R2 not ready at seventh edge");
    expect_at(LAT,     1'b1, "R2 ready at eighth edge");
    step(LAT + 2);
    bus_i = 32'hCAFE_0F0F; ctl_i = 5'b01011;
    #0.5; check_now(1'b1, "R5 pass-through");
    // R6: full reconfiguration via cfg_done.
    step(1);
    done = 0;
    expect_at(2, 1'b1, "R6 still ready at second edge");
    expect_at(3, 1'b0, "R6 drop at third edge");
    step(5);
    bus_i = 32'h0000_0000;
    done = 1;
    expect_at(LAT - 1, 1'b0, "R6 requalify not yet");
    expect_at(LAT,     1'b1, "R6 requalified");
    step(LAT + 2);
    // R6: via io_release.
    rel = 0;
    expect_at(3, 1'b0, "R6 drop on io release");
    step(5);
    rel = 1;
    expect_at(LAT, 1'b1, "R6 requalified after io release");
    step(LAT + 2);
    // R7: partial reconfiguration holds ready.
    partial = 1;
    step(1);
    done = 0; rel = 0;
    expect_at(3, 1'b1, "R7 held during partial");
    expect_at(8, 1'b1, "R7 still held");
    step(9);
    done = 1; rel = 1;
    step(4);
    partial = 0;
    expect_at(3, 1'b1, "R7 ready after partial ends");
    step(5);
    // R8: drop during count, no partial.
    done = 0;
    step(6);
    done = 1;
    step(4);
    done = 0;
    step(1);
    done = 1;
    ctl_i = 5'b11111;
    expect_at(LAT - 1, 1'b0, "R8 restarted count not done");
    expect_at(LAT,     1'b1, "R8 ready after restart");
    step(LAT + 2);
    // R10: drop during count with partial flagged.
    done = 0;
    step(6);
    partial = 1;
    done = 1;
    step(2);
    done = 0;
    step(1);
    done = 1;
    expect_at(LAT - 3, 1'b0, "R10 held count not done");
    expect_at(LAT - 2, 1'b1, "R10 ready one cycle late");
    step(LAT + 2);
    partial = 0;
    step(2);
    // R9: asynchronous reset mid-cycle.
    #0.5; rst_n = 0; #0.2;
    check_now(1'b0, "R9 immediate reset");
    step(2);
    rst_n = 1;
    expect_at(LAT - 1, 1'b0, "R9 released not yet ready");
    expect_at(LAT,     1'b1, "R9 ready after release");
    step(LAT + 3);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expectations unchecked, expected 0", q.size());
    end
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule